// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block is a Clause 22 management slave that lets an MDIO host reach a 32-bit internal register space through 16-bit management frames. It answers one fixed PHY address only. A page register, reached at management register 31, supplies the upper internal address bits. Management registers 0 to 15 pick one 32-bit word inside that 64-byte page and carry its lower half. Register 16 is shared by all words and carries the upper half.

To write a word, the host loads the page, writes the lower half to the indexed register, then writes the upper half to register 16. Only that last write produces a bus cycle. To read a word, the host loads the page, reads the indexed register, then reads register 16. The indexed read fetches and latches the full word, so both halves come from one sample. On the internal side the block issues single-cycle read or write strobes with an address and write data. Read data is taken in the same cycle as the read strobe.

MDC is a slow external clock. It is oversampled by the system clock through a synchronizer. Data on MDIO is sampled on MDC rising edges.

Top module: `mdio_page_bridge`

## Requirements
- R1: Frames whose PHY address field differs from the configured address (default 31) cause no bus strobe, no state change and no drive of the data line.
- R2: A write to management register 31 loads the page (10 bits by default). The page becomes internal address bits [15:6] of later accesses. A read of register 31 returns the page, zero-extended.
- R3: The low 4 bits of the management register number (registers 0 to 15) become internal address bits [5:2]. Address bits [1:0] are always zero.
- R4: A write to registers 0 to 15 only stages the low half and the index, with no bus strobe. A later write to register 16 issues exactly one single-cycle write strobe. The write data is {upper half, staged lower half}, at the current page and the staged index. The most recent staged write wins.
- R5: A read of registers 0 to 15 issues exactly one single-cycle read strobe at that address. The frame returns bits [15:0] of the word read.
- R6: A read of register 16 issues no bus strobe. It returns bits [31:16] latched by the preceding indexed read, even if the register contents changed since.
- R7: A frame is accepted only after at least 32 consecutive ones followed by the start pattern 0,1. Opcode 1,0 is a read and 0,1 is a write. Other opcodes and frames with a shorter preamble are ignored.
- R8: On an accepted read, the line is left released in the first turnaround bit and driven to 0 in the second. Then 16 data bits are driven, most significant first, and the line is released after the last bit. The drive never changes while MDC is low, and the host never meets the block driving while the host drives.
- R9: After reset the data line is released, both bus strobes are low and the page is zero.
- R10: Writes to registers 17 to 30 have no effect, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Management data line, input side |
| mdio_o | output | 1 | Management data line, value driven |
| mdio_oe | output | 1 | Drive enable for the data line |
| reg_addr | output | 16 | Internal byte address |
| reg_wdata | output | 32 | Internal write data |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 32 | Internal read data, valid in the strobe cycle |

## Verification
The hardest case to reach is the consistency of a split read. The upper half must come from the earlier sample, not from the register's present contents. The bench's register model returns a value that depends on both the address and a salt. The bench changes the salt between the indexed read and the register-16 read, so a bridge that re-fetched the word or latched it late would return a different upper half. The ignore cases are shown at the ports. After a foreign PHY address, a short preamble or an illegal opcode, the bench reads the page back and finds it unchanged.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
   localparam int HALF_W = 16;
   localparam int IDX_W  = 4;
   localparam int HDR_W  = 12;
   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;
   localparam logic [4:0] HI_REG   = 5'h10;
   localparam logic [4:0] PAGE_REG = 5'h1F;

   typedef enum logic [2:0] {
      FS_PRE,
      FS_START,
      FS_HDR,
      FS_TA,
      FS_DATA
   } fstate_t;
endpackage

// File: rtl/mpb_sync.sv
module mpb_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mpb_frame.sv
module mpb_frame
   import mpb_pkg::*;
#(
   parameter int PHY_ADDR = 31,
   parameter int PRE_LEN  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdc_s,
   input  logic              mdio_s,
   input  logic [HALF_W-1:0] rsp,
   output logic              rd_go,
   output logic              wr_go,
   output logic [4:0]        req_reg,
   output logic [HALF_W-1:0] wr_data,
   output logic              mdio_o,
   output logic              mdio_oe
);
   localparam int PW    = $clog2(PRE_LEN + 1);
   localparam int CNT_W = (PW > 5) ? PW : 5;
   localparam logic [CNT_W-1:0] PRE_MAX = CNT_W'(PRE_LEN);
   localparam logic [CNT_W-1:0] HDR_END = CNT_W'(HDR_W - 1);
   localparam logic [CNT_W-1:0] DAT_END = CNT_W'(HALF_W - 1);
   localparam logic [4:0]       MY_PHY  = 5'(PHY_ADDR);

   fstate_t           state;
   logic [CNT_W-1:0]  cnt;
   logic [HDR_W-2:0]  hdr;
   logic [HDR_W-1:0]  hdr_n;
   logic [HALF_W-1:0] shreg;
   logic              is_rd;
   logic              mdc_q;
   logic              rise;

   assign rise  = mdc_s & ~mdc_q;
   assign hdr_n = {hdr, mdio_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= FS_PRE;
         cnt     <= '0;
         hdr     <= '0;
         shreg   <= '0;
         is_rd   <= 1'b0;
         mdc_q   <= 1'b0;
         rd_go   <= 1'b0;
         wr_go   <= 1'b0;
         req_reg <= '0;
         wr_data <= '0;
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b0;
      end else begin
         mdc_q <= mdc_s;
         rd_go <= 1'b0;
         wr_go <= 1'b0;
         if (rd_go) shreg <= rsp;
         if (rise) begin
            unique case (state)
               FS_PRE: begin
                  if (mdio_s) begin
                     if (cnt != PRE_MAX) cnt <= cnt + 1'b1;
                  end else if (cnt == PRE_MAX) begin
                     state <= FS_START;
                     cnt   <= '0;
                  end else begin
                     cnt <= '0;
                  end
               end
               FS_START: begin
                  state <= mdio_s ? FS_HDR : FS_PRE;
                  cnt   <= '0;
               end
               FS_HDR: begin
                  hdr <= hdr_n[HDR_W-2:0];
                  if (cnt == HDR_END) begin
                     cnt <= '0;
                     if (hdr_n[9:5] == MY_PHY &&
                         (hdr_n[11:10] == OP_RD || hdr_n[11:10] == OP_WR)) begin
                        state   <= FS_TA;
                        is_rd   <= (hdr_n[11:10] == OP_RD);
                        rd_go   <= (hdr_n[11:10] == OP_RD);
                        req_reg <= hdr_n[4:0];
                     end else begin
                        state <= FS_PRE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               FS_TA: begin
                  if (cnt == '0) begin
                     cnt <= 1;
                     if (is_rd) begin
                        mdio_oe <= 1'b1;
                        mdio_o  <= 1'b0;
                     end
                  end else begin
                     cnt   <= '0;
                     state <= FS_DATA;
                     if (is_rd) begin
                        mdio_o <= shreg[HALF_W-1];
                        shreg  <= shreg << 1;
                     end
                  end
               end
               FS_DATA: begin
                  if (is_rd) begin
                     if (cnt == DAT_END) begin
                        mdio_oe <= 1'b0;
                        mdio_o  <= 1'b0;
                        state   <= FS_PRE;
                        cnt     <= '0;
                     end else begin
                        mdio_o <= shreg[HALF_W-1];
                        shreg  <= shreg << 1;
                        cnt    <= cnt + 1'b1;
                     end
                  end else begin
                     shreg <= {shreg[HALF_W-2:0], mdio_s};
                     if (cnt == DAT_END) begin
                        wr_go   <= 1'b1;
                        wr_data <= {shreg[HALF_W-2:0], mdio_s};
                        state   <= FS_PRE;
                        cnt     <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               default: state <= FS_PRE;
            endcase
         end
      end
   end

   // R8
   ta_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_o);
   // R8
   oe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> (state == FS_TA || state == FS_DATA));
   // R1
   oe_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> is_rd);
endmodule

// File: rtl/mpb_regmap.sv
module mpb_regmap
   import mpb_pkg::*;
#(
   parameter int PAGE_W = 10,
   localparam int ADDR_W = PAGE_W + IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  logic              wr_go,
   input  logic [4:0]        req_reg,
   input  logic [HALF_W-1:0] wr_data,
   output logic [HALF_W-1:0] rsp,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [31:0]       reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   input  logic [31:0]       reg_rdata
);
   logic [PAGE_W-1:0] page;
   logic [HALF_W-1:0] stage_lo;
   logic [IDX_W-1:0]  stage_idx;
   logic [HALF_W-1:0] hold_hi;
   logic              low_sel;

   assign low_sel   = ~req_reg[4];
   assign reg_rd    = rd_go & low_sel;
   assign reg_wr    = wr_go & (req_reg == HI_REG);
   assign reg_wdata = {wr_data, stage_lo};
   assign reg_addr  = {page, (wr_go ? stage_idx : req_reg[IDX_W-1:0]), 2'b00};

   always_comb begin
      if (low_sel)                  rsp = reg_rdata[HALF_W-1:0];
      else if (req_reg == HI_REG)   rsp = hold_hi;
      else if (req_reg == PAGE_REG) rsp = HALF_W'(page);
      else                          rsp = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page      <= '0;
         stage_lo  <= '0;
         stage_idx <= '0;
         hold_hi   <= '0;
      end else begin
         if (wr_go) begin
            if (req_reg == PAGE_REG) begin
               page <= wr_data[PAGE_W-1:0];
            end else if (low_sel) begin
               stage_lo  <= wr_data;
               stage_idx <= req_reg[IDX_W-1:0];
            end
         end
         if (reg_rd) hold_hi <= reg_rdata[31:HALF_W];
      end
   end

   // R4
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);
   // R5
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);
   // R4
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));
   // R2
   page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && req_reg == PAGE_REG) |=> page == $past(wr_data[PAGE_W-1:0]));
   // R6
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(hold_hi));
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
   import mpb_pkg::*;
#(
   parameter int PHY_ADDR    = 31,
   parameter int PAGE_W      = 10,
   parameter int PRE_LEN     = 32,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = PAGE_W + IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdc,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [31:0]       reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   input  logic [31:0]       reg_rdata
);
   if (PHY_ADDR < 0 || PHY_ADDR > 31) begin : g_bad_phy
      $error("PHY_ADDR must fit in five bits");
   end
   if (PAGE_W < 1 || PAGE_W > HALF_W) begin : g_bad_page
      $error("PAGE_W must be between 1 and 16");
   end
   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [1:0]        sync_q;
   logic              rd_go;
   logic              wr_go;
   logic [4:0]        req_reg;
   logic [HALF_W-1:0] wr_data;
   logic [HALF_W-1:0] rsp;

   mpb_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({mdc, mdio_i}),
      .q     (sync_q)
   );

   mpb_frame #(.PHY_ADDR(PHY_ADDR), .PRE_LEN(PRE_LEN)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .mdc_s   (sync_q[1]),
      .mdio_s  (sync_q[0]),
      .rsp     (rsp),
      .rd_go   (rd_go),
      .wr_go   (wr_go),
      .req_reg (req_reg),
      .wr_data (wr_data),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe)
   );

   mpb_regmap #(.PAGE_W(PAGE_W)) u_regmap (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_go     (rd_go),
      .wr_go     (wr_go),
      .req_reg   (req_reg),
      .wr_data   (wr_data),
      .rsp       (rsp),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata)
   );
endmodule

// File: tb/mdio_page_bridge_tb.sv
module mdio_page_bridge_tb;
   typedef struct packed {
      logic        is_wr;
      logic [15:0] addr;
      logic [31:0] data;
   } ev_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mdc = 1'b0;
   logic        host_en = 1'b0;
   logic        host_bit = 1'b1;
   logic        mdio_o, mdio_oe, line;
   logic [15:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        reg_wr, reg_rd;
   logic [31:0] salt = 32'h5A5A_0F0F;
   int          tests = 0;
   int          fails = 0;
   int          conflicts = 0;
   int          low_changes = 0;
   int          oe_cycles = 0;
   ev_t         expq[$];

   always #10 clk = ~clk;

   assign line      = mdio_oe ? mdio_o : (host_en ? host_bit : 1'b1);
   assign reg_rdata = {reg_addr, ~reg_addr} ^ salt;

   mdio_page_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(line),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_rdata(reg_rdata)
   );

   function automatic logic [31:0] model(input logic [15:0] a, input logic [31:0] s);
      return {a, ~a} ^ s;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   logic       mdc_prev = 1'b0;
   logic [1:0] out_prev = 2'b00;
   always @(negedge clk) begin
      if (rst_n) begin
         if (host_en && mdio_oe) conflicts++;
         if (mdio_oe) oe_cycles++;
         if (!mdc && !mdc_prev && ({mdio_oe, mdio_o} != out_prev)) low_changes++;
         if (reg_wr || reg_rd) begin
            if (expq.size() == 0) begin
               chk("R1/R4/R6 unexpected strobe", {30'd0, reg_wr, reg_rd}, 32'd0);
            end else begin
               ev_t e;
               e = expq.pop_front();
               chk("R4/R5 strobe kind", {31'd0, reg_wr}, {31'd0, e.is_wr});
               chk("R3 strobe addr", {16'd0, reg_addr}, {16'd0, e.addr});
               if (e.is_wr) chk("R4 write data", reg_wdata, e.data);
            end
         end
      end
      mdc_prev = mdc;
      out_prev = {mdio_oe, mdio_o};
   end

   task automatic bit_io(input logic drv, input logic b, output logic smp);
      @(negedge clk);
      mdc = 1'b0; host_en = drv; host_bit = b;
      repeat (4) @(negedge clk);
      smp = line;
      mdc = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input int pre, input logic resp,
                        output logic [15:0] rd);
      logic s;
      logic [13:0] hdr;
      hdr = {2'b01, op, phy, rg};
      rd = '0;
      for (int i = 0; i < pre; i++) bit_io(1'b1, 1'b1, s);
      for (int i = 13; i >= 0; i--) bit_io(1'b1, hdr[i], s);
      if (op == 2'b10) begin
         bit_io(1'b0, 1'b1, s);
         if (resp) chk("R8 first turnaround released", {31'd0, s}, 32'd1);
         bit_io(1'b0, 1'b1, s);
         if (resp) chk("R8 second turnaround zero", {31'd0, s}, 32'd0);
         for (int i = 15; i >= 0; i--) begin
            bit_io(1'b0, 1'b1, s);
            rd[i] = s;
         end
      end else begin
         bit_io(1'b1, 1'b1, s);
         bit_io(1'b1, 1'b0, s);
         for (int i = 15; i >= 0; i--) bit_io(1'b1, wd[i], s);
      end
      bit_io(1'b0, 1'b1, s);
      bit_io(1'b0, 1'b1, s);
      if (resp) chk("R8 released after frame", {31'd0, mdio_oe}, 32'd0);
   endtask

   task automatic mwr(input logic [4:0] rg, input logic [15:0] d);
      logic [15:0] r;
      frame(2'b01, 5'd31, rg, d, 32, 1'b0, r);
   endtask

   task automatic mrd(input logic [4:0] rg, output logic [15:0] d);
      frame(2'b10, 5'd31, rg, 16'h0, 32, 1'b1, d);
   endtask

   task automatic push(input logic w, input logic [15:0] a, input logic [31:0] d);
      ev_t e;
      e.is_wr = w; e.addr = a; e.data = d;
      expq.push_back(e);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [15:0] r;
      logic [15:0] a;
      logic [31:0] old_salt;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 oe after reset", {31'd0, mdio_oe}, 32'd0);
      chk("R9 strobes after reset", {30'd0, reg_wr, reg_rd}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      mrd(5'h1F, r);
      chk("R9 page zero after reset", {16'd0, r}, 32'd0);

      // R2 page load and readback
      mwr(5'h1F, 16'h02A5);
      mrd(5'h1F, r);
      chk("R2 page readback", {16'd0, r}, 32'h02A5);

      // R4 staged write, R3 address
      mwr(5'h03, 16'hBEEF);
      chk("R4 no strobe on low write", expq.size(), 0);
      push(1'b1, {10'h2A5, 4'd3, 2'b00}, 32'h1234_BEEF);
      mwr(5'h10, 16'h1234);
      chk("R4 write consumed", expq.size(), 0);

      // R4 latest staged write wins
      mwr(5'h07, 16'h1111);
      mwr(5'h09, 16'h2222);
      push(1'b1, {10'h2A5, 4'd9, 2'b00}, 32'hABCD_2222);
      mwr(5'h10, 16'hABCD);
      chk("R4 latest stage consumed", expq.size(), 0);

      // R5 low read, R3 index 15
      a = {10'h2A5, 4'hF, 2'b00};
      push(1'b0, a, 32'h0);
      mrd(5'h0F, r);
      chk("R5 low half", {16'd0, r}, {16'd0, model(a, salt)[15:0]});

      // R6 high half comes from latched sample
      old_salt = salt;
      salt = 32'hC3C3_9696;
      mrd(5'h10, r);
      chk("R6 latched upper half", {16'd0, r}, {16'd0, model(a, old_salt)[31:16]});

      // R1 foreign PHY ignored
      oe_cycles = 0;
      frame(2'b10, 5'd5, 5'h00, 16'h0, 32, 1'b0, r);
      chk("R1 foreign read line released", {16'd0, r}, 32'h0000_FFFF);
      chk("R1 no drive for foreign PHY", oe_cycles, 0);
      frame(2'b01, 5'd7, 5'h1F, 16'h0155, 32, 1'b0, r);
      mrd(5'h1F, r);
      chk("R1 foreign write leaves page", {16'd0, r}, 32'h02A5);

      // R7 short preamble and bad opcode ignored
      frame(2'b01, 5'd31, 5'h1F, 16'h0077, 20, 1'b0, r);
      mrd(5'h1F, r);
      chk("R7 short preamble ignored", {16'd0, r}, 32'h02A5);
      frame(2'b11, 5'd31, 5'h1F, 16'h0066, 32, 1'b0, r);
      mrd(5'h1F, r);
      chk("R7 bad opcode ignored", {16'd0, r}, 32'h02A5);

      // R10 unused registers
      mwr(5'h15, 16'h0003);
      mrd(5'h15, r);
      chk("R10 unused reads zero", {16'd0, r}, 32'd0);
      mrd(5'h1F, r);
      chk("R10 unused write leaves page", {16'd0, r}, 32'h02A5);

      // R3 boundaries: top page index 0, page 0 index 0
      mwr(5'h1F, 16'h03FF);
      mwr(5'h00, 16'h00AA);
      push(1'b1, 16'hFFC0, 32'h5500_00AA);
      mwr(5'h10, 16'h5500);
      mwr(5'h1F, 16'h0000);
      push(1'b0, 16'h0000, 32'h0);
      mrd(5'h00, r);
      chk("R3 page 0 index 0 read", {16'd0, r}, {16'd0, model(16'h0000, salt)[15:0]});

      chk("R4 scoreboard drained", expq.size(), 0);
      chk("R8 no contention", conflicts, 0);
      chk("R8 no drive change while MDC low", low_changes, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule